// File: doc/BRIEF.md
# Framing Error Insertion Controller

This block sits in the serial transmit path of an E3 framer. On request it corrupts the frame alignment word so that a far-end receiver's loss-of-alignment handling can be tested. It produces a one-bit inversion mask that the framer XORs onto the outgoing data bit in the same clock cycle. The framer marks the alignment word bit positions with a strobe. It sends one bit per clock, and the alignment word is the first 10 bits of each frame, sent MSB first.

A request comes from either a software trigger bit or a hardware trigger pin. A mode-select bit chooses between them. The block detects the rising edge of the selected trigger, and any number of edges before the next alignment word collapse into one pending event. A 2-bit mode field chooses the event's shape. The event can invert only the first alignment bit or all 10 bits. It can cover one frame or four consecutive frames. A four-frame event always runs to the end. A request that arrives during it is held and served at the frame after the event ends. A master enable bit blocks all insertion.

Top module: `fei_err_inject`

## Requirements
- R1: After reset the mask is 0, and a frame with no trigger activity carries no inverted bit.
- R2: Mode 00 (bit 1 of the mode field = four frames, bit 0 = whole word) inverts only the first alignment bit of one frame. The mask is never 1 outside the alignment strobe.
- R3: Mode 01 inverts all 10 alignment bits of one frame.
- R4: Mode 10 inverts the first alignment bit in each of four consecutive frames, and the fifth frame is clean.
- R5: Mode 11 inverts all 10 alignment bits in each of four consecutive frames, and the fifth frame is clean.
- R6: While the enable is 0 the mask is 0. Requests that arrive while the enable is 0 are discarded. Clearing the enable aborts an event in progress, and the remaining frames are not corrupted after the enable returns.
- R7: With mode-select 0, a 0-to-1 transition of the software trigger requests one event. A trigger held high requests nothing more until it falls and rises again.
- R8: With mode-select 1, the hardware trigger pin requests events and the software trigger is ignored.
- R9: Several trigger rises before the next alignment word produce exactly one event.
- R10: Switching mode-select to a source that is already high counts as a rising edge and requests an event.
- R11: A request that arrives during a four-frame event is held as one pending event. It starts at the first frame after the event ends.
- R12: The mode field is sampled at the first alignment bit of the frame where an event starts. A mode change during a four-frame event does not alter that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Event shape: bit 0 selects the whole word, bit 1 selects four frames |
| en_i | input | 1 | Insertion enable |
| sw_trig_i | input | 1 | Software trigger bit |
| src_sel_i | input | 1 | Trigger source: 0 selects software, 1 selects the hardware pin |
| hw_trig_i | input | 1 | Hardware trigger pin |
| fas_strobe_i | input | 1 | High during the alignment word bits of each frame |
| err_mask_o | output | 1 | Inversion mask XORed onto the transmit bit |

## Verification
All four mode values are driven from single trigger pulses. The per-frame mask is classified as clean, first bit only, full word, or other, which separates the bit modes from the word modes and the one-frame shape from the four-frame shape. Trigger patterns cover bursts of pulses, a held level, a source switch onto a high pin, and a pulse inside a running four-frame event. Together these show that edges are merged, held levels are ignored, the mux output is edge-detected, and a late request waits for the event in progress. Enable toggling before and during an event, plus a mode change mid-event, shows that requests are dropped, events abort, and the mode is captured once per event.

// File: rtl/fei_pkg.sv
package fei_pkg;

  typedef enum logic [1:0] {
    FEI_BIT_ONE    = 2'b00,
    FEI_WORD_ONE   = 2'b01,
    FEI_BIT_MULTI  = 2'b10,
    FEI_WORD_MULTI = 2'b11
  } fei_mode_e;

  function automatic logic fei_is_word(input fei_mode_e m);
    return m[0];
  endfunction

  function automatic logic fei_is_multi(input fei_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/fei_trig_edge.sv
module fei_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_sel_i,
  input  logic sw_trig_i,
  input  logic hw_trig_i,
  output logic rise_o
);
  logic trig_mux;
  logic trig_q;

  // edge-detect after the mux so a source switch onto a high level counts
  assign trig_mux = src_sel_i ? hw_trig_i : sw_trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_mux;
  end

  assign rise_o = trig_mux & ~trig_q;
endmodule

// File: rtl/fei_req_hold.sv
module fei_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  input  logic take_i,
  output logic pending_o
);
  logic pending_q;
  logic pending_d;

  always_comb begin
    pending_d = pending_q;
    if (take_i) pending_d = 1'b0;
    if (rise_i) pending_d = 1'b1;
    if (!en_i)  pending_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= pending_d;
  end

  assign pending_o = pending_q;
endmodule

// File: rtl/fei_fas_track.sv
module fei_fas_track #(
  parameter int FAS_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic first_bit_o,
  output logic in_fas_o
);
  localparam int CNT_W = $clog2(FAS_BITS + 1);

  logic             strobe_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (!strobe_i)
        cnt_q <= '0;
      else if (cnt_q < CNT_W'(FAS_BITS))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign first_bit_o = strobe_i & ~strobe_q;
  assign in_fas_o    = strobe_i & (cnt_q < CNT_W'(FAS_BITS));
endmodule

// File: rtl/fei_event_seq.sv
module fei_event_seq
  import fei_pkg::*;
#(
  parameter int MULTI_FRAMES = 4,
  parameter int LEFT_W       = $clog2(MULTI_FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  fei_mode_e         mode_i,
  input  logic              pending_i,
  input  logic              first_bit_i,
  input  logic              in_fas_i,
  output logic              take_o,
  output logic [LEFT_W-1:0] left_o,
  output logic              mask_o
);
  logic [LEFT_W-1:0] left_q, left_d;
  logic              word_q, word_d;
  logic              active_q, active_d;
  logic              busy, start, cont, hit, word_now;

  assign busy     = (left_q != '0);
  assign start    = first_bit_i & en_i & pending_i & ~busy;
  assign cont     = first_bit_i & en_i & busy;
  assign hit      = start | cont;
  assign word_now = start ? fei_is_word(mode_i) : word_q;

  always_comb begin
    left_d   = left_q;
    word_d   = word_q;
    active_d = active_q;
    if (start) begin
      word_d = fei_is_word(mode_i);
      left_d = fei_is_multi(mode_i) ? LEFT_W'(MULTI_FRAMES - 1) : '0;
    end else if (cont) begin
      left_d = left_q - 1'b1;
    end
    if (first_bit_i)    active_d = hit & word_now;
    else if (!in_fas_i) active_d = 1'b0;
    if (!en_i) begin
      left_d   = '0;
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q   <= '0;
      word_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      left_q   <= left_d;
      word_q   <= word_d;
      active_q <= active_d;
    end
  end

  assign take_o = start;
  assign left_o = left_q;
  assign mask_o = en_i & in_fas_i & (first_bit_i ? hit : active_q);
endmodule

// File: rtl/fei_err_inject.sv
module fei_err_inject
  import fei_pkg::*;
#(
  parameter int FAS_BITS     = 10,
  parameter int MULTI_FRAMES = 4,
  localparam int LEFT_W      = $clog2(MULTI_FRAMES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       sw_trig_i,
  input  logic       src_sel_i,
  input  logic       hw_trig_i,
  input  logic       fas_strobe_i,
  output logic       err_mask_o
);
  logic              trig_rise;
  logic              pending;
  logic              take;
  logic              first_bit;
  logic              in_fas;
  logic [LEFT_W-1:0] frames_left;

  fei_trig_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sel_i (src_sel_i),
    .sw_trig_i (sw_trig_i),
    .hw_trig_i (hw_trig_i),
    .rise_o    (trig_rise)
  );

  fei_req_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .rise_i    (trig_rise),
    .take_i    (take),
    .pending_o (pending)
  );

  fei_fas_track #(.FAS_BITS(FAS_BITS)) u_fas (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (fas_strobe_i),
    .first_bit_o (first_bit),
    .in_fas_o    (in_fas)
  );

  fei_event_seq #(.MULTI_FRAMES(MULTI_FRAMES), .LEFT_W(LEFT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (fei_mode_e'(mode_i)),
    .pending_i   (pending),
    .first_bit_i (first_bit),
    .in_fas_i    (in_fas),
    .take_o      (take),
    .left_o      (frames_left),
    .mask_o      (err_mask_o)
  );
endmodule

// File: rtl/fei_err_inject_chk.sv
module fei_err_inject_chk #(
  parameter int LEFT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              sw_trig_i,
  input logic              src_sel_i,
  input logic              hw_trig_i,
  input logic              fas_strobe_i,
  input logic              err_mask_o,
  input logic              pending_i,
  input logic [LEFT_W-1:0] left_i
);
  // R2
  mask_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_mask_o |-> fas_strobe_i);

  // R6
  dis_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pending_i && left_i == '0));

  // R7
  pend_from_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_i) |-> $past(src_sel_i ? hw_trig_i : sw_trig_i));

  // R4
  left_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_i != '0 && en_i) |=>
      (left_i == $past(left_i) || left_i == $past(left_i) - 1'b1));

  // R3
  word_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_mask_o && fas_strobe_i && $past(fas_strobe_i)) |-> $past(err_mask_o));
endmodule

bind fei_err_inject fei_err_inject_chk #(.LEFT_W(LEFT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .sw_trig_i    (sw_trig_i),
  .src_sel_i    (src_sel_i),
  .hw_trig_i    (hw_trig_i),
  .fas_strobe_i (fas_strobe_i),
  .err_mask_o   (err_mask_o),
  .pending_i    (pending),
  .left_i       (frames_left)
);

// File: tb/fei_err_inject_bench.sv
`timescale 1ns/1ps
module fei_err_inject_bench;
  localparam int FAS   = 10;
  localparam int FRAME = 40;
  // frame classes
  localparam int K_NONE = 0, K_BIT = 1, K_WORD = 2, K_BAD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       en = 1'b0;
  logic       sw_trig = 1'b0;
  logic       src_sel = 1'b0;
  logic       hw_trig = 1'b0;
  logic       fas_strobe = 1'b0;
  logic       err_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fei_err_inject u_fei_err_inject (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .en_i         (en),
    .sw_trig_i    (sw_trig),
    .src_sel_i    (src_sel),
    .hw_trig_i    (hw_trig),
    .fas_strobe_i (fas_strobe),
    .err_mask_o   (err_mask)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame; optional software pulse at cycle pulse_cyc
  task automatic run_frame(input int pulse_cyc, output int kind);
    logic [FAS-1:0] seen;
    bit outside;
    seen = '0;
    outside = 0;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      fas_strobe = (c < FAS);
      if (pulse_cyc >= 0 && c == pulse_cyc)     sw_trig = 1'b1;
      if (pulse_cyc >= 0 && c == pulse_cyc + 1) sw_trig = 1'b0;
      #1;
      if (err_mask) begin
        if (c < FAS) seen[c] = 1'b1;
        else         outside = 1;
      end
    end
    if (outside)              kind = K_BAD;
    else if (seen == '0)      kind = K_NONE;
    else if (seen == 10'd1)   kind = K_BIT;
    else if (&seen)           kind = K_WORD;
    else                      kind = K_BAD;
  endtask

  task automatic frame_expect(input string req, input int exp);
    int k;
    run_frame(-1, k);
    chk(req, k, exp);
  endtask

  task automatic sw_pulse();
    @(negedge clk) sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
  endtask

  task automatic hw_pulse();
    @(negedge clk) hw_trig = 1'b1;
    @(negedge clk) hw_trig = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    chk("R1 mask in reset", int'(err_mask), 0);
    @(negedge clk) rst_n = 1'b1;
    en = 1'b1;
    frame_expect("R1 idle frame", K_NONE);
  endtask

  task automatic test_modes();
    mode = 2'b00; sw_pulse();
    frame_expect("R2 mode00 frame1", K_BIT);
    frame_expect("R2 mode00 frame2", K_NONE);
    mode = 2'b01; sw_pulse();
    frame_expect("R3 mode01 frame1", K_WORD);
    frame_expect("R3 mode01 frame2", K_NONE);
    mode = 2'b10; sw_pulse();
    for (int f = 0; f < 4; f++) frame_expect("R4 mode10 run", K_BIT);
    frame_expect("R4 mode10 frame5", K_NONE);
    mode = 2'b11; sw_pulse();
    for (int f = 0; f < 4; f++) frame_expect("R5 mode11 run", K_WORD);
    frame_expect("R5 mode11 frame5", K_NONE);
  endtask

  task automatic test_disable();
    mode = 2'b01;
    @(negedge clk) en = 1'b0;
    sw_pulse();
    frame_expect("R6 disabled frame", K_NONE);
    @(negedge clk) en = 1'b1;
    frame_expect("R6 dropped request", K_NONE);
    mode = 2'b11; sw_pulse();
    frame_expect("R6 abort frame1", K_WORD);
    @(negedge clk) en = 1'b0;
    frame_expect("R6 abort frame2", K_NONE);
    @(negedge clk) en = 1'b1;
    frame_expect("R6 after abort", K_NONE);
  endtask

  task automatic test_sw_hold();
    mode = 2'b00;
    @(negedge clk) sw_trig = 1'b1;
    frame_expect("R7 rise", K_BIT);
    frame_expect("R7 held high", K_NONE);
    @(negedge clk) sw_trig = 1'b0;
    frame_expect("R7 fall only", K_NONE);
    sw_pulse();
    frame_expect("R7 second rise", K_BIT);
  endtask

  task automatic test_burst();
    mode = 2'b00;
    sw_pulse(); sw_pulse(); sw_pulse();
    frame_expect("R9 burst frame1", K_BIT);
    frame_expect("R9 burst frame2", K_NONE);
  endtask

  task automatic test_hw_src();
    mode = 2'b01;
    @(negedge clk) src_sel = 1'b1;
    sw_pulse();
    frame_expect("R8 sw ignored", K_NONE);
    hw_pulse();
    frame_expect("R8 hw pulse", K_WORD);
    frame_expect("R8 hw after", K_NONE);
    @(negedge clk) src_sel = 1'b0;
  endtask

  task automatic test_sel_switch();
    mode = 2'b00;
    @(negedge clk) hw_trig = 1'b1;
    frame_expect("R10 unselected high", K_NONE);
    @(negedge clk) src_sel = 1'b1;
    frame_expect("R10 switch request", K_BIT);
    frame_expect("R10 after switch", K_NONE);
    @(negedge clk) hw_trig = 1'b0;
    @(negedge clk) src_sel = 1'b0;
    frame_expect("R10 restore", K_NONE);
  endtask

  task automatic test_pending_in_run();
    int k;
    mode = 2'b11; sw_pulse();
    run_frame(20, k);
    chk("R11 run frame1", k, K_WORD);
    mode = 2'b00;
    run_frame(15, k);
    chk("R12 run frame2 keeps word", k, K_WORD);
    run_frame(25, k);
    chk("R12 run frame3 keeps word", k, K_WORD);
    frame_expect("R12 run frame4 keeps word", K_WORD);
    frame_expect("R11 held request served", K_BIT);
    frame_expect("R11 single held event", K_NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_modes();
    test_disable();
    test_sw_hold();
    test_burst();
    test_hw_src();
    test_sel_switch();
    test_pending_in_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule